// File: doc/BRIEF.md
# Selectable-Prescale Baud Tick Generator

This block derives the timing enables for an asynchronous serial port from a single fast reference clock of 18.432 MHz. The reference is first divided by a prescaler whose ratio is set by a static configuration input. The standard setting divides by ten, which recovers the customary 1.8432 MHz serial input rate. The alternative setting passes a faster rate, by default the full reference. A 16-bit programmable divisor then counts prescaled enables and emits a 16x oversampling tick. A further divide-by-sixteen produces a bit-rate tick.

Both outputs are one-cycle enables in the reference clock domain; they are not derived clocks. Software-style configuration arrives as a divisor word with a load strobe. The captured value is applied only when the running count next reloads, so the period in progress always finishes intact. A divisor of zero halts the ticks.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset, tick16x and tickBit are low and stay low until a nonzero divisor has been loaded.
- R2: With prescaleSel = 0 the reference is divided by 10, so with a loaded divisor N (N >= 1) successive tick16x pulses are exactly 10*N reference cycles apart.
- R3: With prescaleSel = 1 the reference is divided by 1, so with divisor N successive tick16x pulses are exactly N reference cycles apart (divisor 1 gives a tick every cycle).
- R4: With prescaleSel = 0 the standard divisors give the expected 16x tick spacing: 12 (9600 baud) every 120 cycles, 384 (300 baud) every 3840, 2304 (50 baud) every 23040, 1047 (about 110 baud) every 10470 and 2 (about 56000 baud) every 20.
- R5: tickBit pulses once for every sixteen tick16x pulses, always in a cycle in which tick16x is also high, so its spacing is 16 times the tick16x spacing.
- R6: Loading divisor 0 lets the period in progress end with one final tick16x, after which no tick is produced until a nonzero divisor is loaded; ticks then resume at the new rate.
- R7: A divisor loaded in mid-period does not alter that period; the new value governs the spacing from the next reload onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 18.432 MHz reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| prescaleSel | input | 1 | Prescale ratio select: 0 = divide by 10, 1 = fast ratio |
| divisorIn | input | 16 | Divisor value to be captured |
| divisorLoad | input | 1 | One-cycle strobe capturing divisorIn |
| tick16x | output | 1 | One-cycle 16x oversampling enable |
| tickBit | output | 1 | One-cycle bit-rate enable |

## Verification
The bench sweeps small divisors under both prescale ratios and measures the exact spacing between ticks. A prescaler or divisor that is off by one shows up there as a period one cycle or one prescale step too long or too short. Standard rates are checked at their full length, and the bit tick is timed against sixteen 16x periods. That catches an oversample counter that wraps at 15 or 17, or one that fires out of step with the 16x tick. A divisor change in mid-period is timed across the boundary, which exposes a design that applies the new value at once. Loading zero and then a new value checks that the ticks stop after exactly one more pulse and that they restart.

// File: rtl/baud_pkg.sv
package baud_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic step;
    logic reload;
    logic fire16;
    logic fireBit;
  } strobes_t;

  // status from datapath back to control
  typedef struct packed {
    logic cntLow;
    logic cntOne;
    logic subLast;
  } status_t;

endpackage

// File: rtl/baud_prescaler.sv
module baud_prescaler #(
  parameter int PRE_STD  = 10,
  parameter int PRE_FAST = 1
) (
  input  logic clk,
  input  logic rstN,
  input  logic sel,
  output logic preEn
);
  localparam int PRE_MAX = (PRE_STD > PRE_FAST) ? PRE_STD : PRE_FAST;
  localparam int PRE_W   = (PRE_MAX > 1) ? $clog2(PRE_MAX) : 1;

  generate
    if (PRE_MAX == 1) begin : g_bypass
      assign preEn = 1'b1;
    end else begin : g_count
      localparam logic [PRE_W-1:0] LAST_STD  = PRE_W'(PRE_STD - 1);
      localparam logic [PRE_W-1:0] LAST_FAST = PRE_W'(PRE_FAST - 1);

      logic [PRE_W-1:0] preCnt;
      logic [PRE_W-1:0] lastVal;

      assign lastVal = sel ? LAST_FAST : LAST_STD;
      // >= lets a switch to a shorter ratio recover in one cycle
      assign preEn = (preCnt >= lastVal);

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)      preCnt <= '0;
        else if (preEn) preCnt <= '0;
        else            preCnt <= preCnt + 1'b1;
      end

      // R2 / R3: with a steady select the count never passes its terminal value
      p_pre_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
        $stable(sel) |-> (preCnt <= lastVal));
    end
  endgenerate

endmodule

// File: rtl/baud_ctrl.sv
module baud_ctrl
  import baud_pkg::*;
(
  input  logic     preEn,
  input  logic     divisorLoad,
  input  status_t  st,
  output strobes_t stb
);
  always_comb begin
    stb.capture = divisorLoad;
    stb.step    = preEn;
    // reload when the count is at its last step or idle at zero
    stb.reload  = preEn & st.cntLow;
    stb.fire16  = preEn & st.cntOne;
    stb.fireBit = preEn & st.cntOne & st.subLast;
  end
endmodule

// File: rtl/baud_datapath.sv
module baud_datapath
  import baud_pkg::*;
#(
  parameter int DIV_W      = 16,
  parameter int OVERSAMPLE = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobes_t         stb,
  input  logic [DIV_W-1:0] divisorIn,
  output status_t          st,
  output logic             tick16x,
  output logic             tickBit
);
  localparam int               SUB_W    = (OVERSAMPLE > 2) ? $clog2(OVERSAMPLE) : 1;
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVERSAMPLE - 1);

  logic [DIV_W-1:0] heldDiv;
  logic [DIV_W-1:0] cnt;
  logic [SUB_W-1:0] sub;
  logic             tick16Q;
  logic             tickBitQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldDiv  <= '0;
      cnt      <= '0;
      sub      <= '0;
      tick16Q  <= 1'b0;
      tickBitQ <= 1'b0;
    end else begin
      if (stb.capture) heldDiv <= divisorIn;
      if (stb.reload)    cnt <= heldDiv;
      else if (stb.step) cnt <= cnt - 1'b1;
      if (stb.fire16) begin
        if (sub == SUB_LAST) sub <= '0;
        else                 sub <= sub + 1'b1;
      end
      tick16Q  <= stb.fire16;
      tickBitQ <= stb.fireBit;
    end
  end

  always_comb begin
    st.cntLow  = (cnt <= DIV_W'(1));
    st.cntOne  = (cnt == DIV_W'(1));
    st.subLast = (sub == SUB_LAST);
  end

  assign tick16x = tick16Q;
  assign tickBit = tickBitQ;

  // R7: a reload takes the captured divisor as it stood before the edge
  p_reload_r7: assert property (@(posedge clk) disable iff (!rstN)
    stb.reload |=> (cnt == $past(heldDiv)));

  // R2: between reloads the count moves down one per prescaled enable
  p_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (stb.step && !stb.reload) |=> (cnt == $past(cnt) - 1'b1));

  // R6: an idle (zero) count never yields a tick in the next cycle
  p_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    (cnt == '0) |=> !tick16x);

  // R5: the bit tick coincides with a 16x tick
  p_bit_with_tick_r5: assert property (@(posedge clk) disable iff (!rstN)
    tickBit |-> tick16x);

  // R5: the oversample counter restarts after the bit tick
  p_sub_wrap_r5: assert property (@(posedge clk) disable iff (!rstN)
    stb.fireBit |=> (sub == '0));

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import baud_pkg::*;
#(
  parameter int DIV_W      = 16,
  parameter int PRE_STD    = 10,
  parameter int PRE_FAST   = 1,
  parameter int OVERSAMPLE = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             prescaleSel,
  input  logic [DIV_W-1:0] divisorIn,
  input  logic             divisorLoad,
  output logic             tick16x,
  output logic             tickBit
);
  logic     preEn;
  strobes_t stb;
  status_t  st;

  baud_prescaler #(
    .PRE_STD (PRE_STD),
    .PRE_FAST(PRE_FAST)
  ) u_pre (
    .clk  (clk),
    .rstN (rstN),
    .sel  (prescaleSel),
    .preEn(preEn)
  );

  baud_ctrl u_ctrl (
    .preEn      (preEn),
    .divisorLoad(divisorLoad),
    .st         (st),
    .stb        (stb)
  );

  baud_datapath #(
    .DIV_W     (DIV_W),
    .OVERSAMPLE(OVERSAMPLE)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .divisorIn(divisorIn),
    .st       (st),
    .tick16x  (tick16x),
    .tickBit  (tickBit)
  );

endmodule

// File: tb/baud_tick_gen_test.sv
module baud_tick_gen_test;
  localparam int STD_RATIO  = 10;
  localparam int FAST_RATIO = 1;
  localparam int GUARD      = 30000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        prescaleSel = 1'b0;
  logic [15:0] divisorIn = '0;
  logic        divisorLoad = 1'b0;
  logic        tick16x;
  logic        tickBit;

  int     vectors = 0;
  int     misses = 0;
  longint cycleNo = 0;

  baud_tick_gen uut (
    .clk        (clk),
    .rstN       (rstN),
    .prescaleSel(prescaleSel),
    .divisorIn  (divisorIn),
    .divisorLoad(divisorLoad),
    .tick16x    (tick16x),
    .tickBit    (tickBit)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cycleNo <= cycleNo + 1;

  task automatic check(input string req, input longint act, input longint exp);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ratioOf(input logic sel);
    return sel ? FAST_RATIO : STD_RATIO;
  endfunction

  task automatic loadDiv(input logic sel, input int n);
    @(negedge clk);
    prescaleSel = sel;
    divisorIn   = 16'(n);
    divisorLoad = 1'b1;
    @(negedge clk);
    divisorLoad = 1'b0;
  endtask

  task automatic nextTick(input bit useBit, output longint at);
    int guard = 0;
    do begin
      @(negedge clk);
      guard++;
    end while (!(useBit ? tickBit : tick16x) && guard < GUARD);
    at = (guard >= GUARD) ? -1 : cycleNo;
  endtask

  task automatic countTicks(input int cycles, output int seen);
    seen = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (tick16x || tickBit) seen++;
    end
  endtask

  task automatic finishRun();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    misses++;
    $display("FAIL watchdog actual=expired expected=finished");
    finishRun();
  end

  initial begin
    longint t0, t1, t2;
    int seen;
    int stdSet [5] = '{12, 384, 1047, 2304, 2};

    // R1: reset state and silence before any divisor
    repeat (5) @(negedge clk);
    check("R1 tick16x in reset", longint'(tick16x), 0);
    check("R1 tickBit in reset", longint'(tickBit), 0);
    rstN = 1'b1;
    countTicks(200, seen);
    check("R1 no ticks with zero divisor", seen, 0);

    // R2 (sel 0) and R3 (sel 1): sweep small divisors
    for (int s = 0; s < 2; s++) begin
      for (int n = 1; n <= 24; n++) begin
        loadDiv(s[0], n);
        nextTick(0, t1);
        nextTick(0, t2);
        check(s == 0 ? "R2 tick16x spacing" : "R3 tick16x spacing",
              t2 - t1, longint'(ratioOf(s[0]) * n));
      end
    end

    // R4: standard divisor table under divide-by-10
    foreach (stdSet[k]) begin
      loadDiv(1'b0, stdSet[k]);
      nextTick(0, t1);
      nextTick(0, t2);
      check("R4 standard rate spacing", t2 - t1, longint'(STD_RATIO * stdSet[k]));
    end

    // R5: bit tick spacing and coincidence
    loadDiv(1'b1, 1);
    nextTick(0, t0);
    nextTick(1, t1);
    nextTick(1, t2);
    check("R5 bit spacing fast n=1", t2 - t1, 16);
    check("R5 bit with 16x tick", longint'(tick16x), 1);
    loadDiv(1'b0, 3);
    nextTick(0, t0);
    nextTick(1, t1);
    nextTick(1, t2);
    check("R5 bit spacing std n=3", t2 - t1, 480);
    loadDiv(1'b0, 12);
    nextTick(0, t0);
    nextTick(1, t1);
    nextTick(1, t2);
    check("R5 bit spacing std n=12", t2 - t1, 1920);
    check("R5 bit with 16x tick n=12", longint'(tick16x), 1);

    // R7: mid-period divisor change waits for the next reload
    loadDiv(1'b0, 20);
    nextTick(0, t0);
    nextTick(0, t0);
    repeat (3) @(negedge clk);
    loadDiv(1'b0, 5);
    nextTick(0, t1);
    nextTick(0, t2);
    check("R7 old period completes", t1 - t0, 200);
    check("R7 new period applies", t2 - t1, 50);

    // R6: divisor zero stops after one more tick, then restart
    loadDiv(1'b0, 8);
    nextTick(0, t0);
    nextTick(0, t0);
    repeat (3) @(negedge clk);
    loadDiv(1'b0, 0);
    nextTick(0, t1);
    check("R6 final tick at old spacing", t1 - t0, 80);
    countTicks(1000, seen);
    check("R6 silent after zero", seen, 0);
    loadDiv(1'b0, 4);
    nextTick(0, t1);
    nextTick(0, t2);
    check("R6 restart spacing", t2 - t1, 40);

    finishRun();
  end

endmodule